// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates 32-bit virtual addresses into physical addresses by walking a two-level radix page table in memory. Pages are 4 KiB. Each level is indexed by 10 virtual-address bits, and each table entry is one 32-bit word. A leaf found at the upper level maps a 4 MiB superpage. The block takes one translation at a time. Each request carries the access kind, the current privilege, the status bits that affect translation, the root table page number and the translation mode. The block returns a physical address with its read/write/execute grants, or a fault.

Memory is reached through one request port that carries two kinds of request: word reads, and compare-and-swap writes used to set the accessed and dirty bits. A compare-and-swap returns the old word. If that word no longer matches the entry the walker read, the walk restarts from the root table. If memory reports an error on the write-back, the translation faults.

Top module: `pt_walker`

## Requirements
- R1: The effective privilege equals `req_priv`, except for a load (access 1) or store (access 2) requested in machine mode (priv 3) with `req_mprv` set, which uses `req_mpp` instead. A fetch (access 0) always uses `req_priv`. Privilege codes: 0 user, 1 supervisor, 3 machine.
- R2: When the effective privilege is machine, or `req_paged` is 0 (bare), the response gives the virtual address zero-extended as the physical address, grants read, write and execute, reports no fault, and makes no memory request.
- R3: The first read is at root_ppn*4096 + vaddr[31:22]*4. For a pointer entry, the second read is at ppn*4096 + vaddr[21:12]*4. Entry layout: V bit 0, R bit 1, W bit 2, X bit 3, U bit 4, A bit 6, D bit 7, page number bits 31:10.
- R4: An entry with V clear faults. An entry with R, W and X all clear is a pointer, and a pointer at the second level faults.
- R5: A leaf with W set and R clear (W alone, or W with X) faults.
- R6: A leaf with U set faults when the effective privilege is not user and either `req_sum` is 0 or the access is a fetch. A leaf with U clear faults when the effective privilege is not supervisor.
- R7: A first-level leaf whose page number bits 9:0 are not all zero faults.
- R8: A load needs R, or X with `req_mxr` set. A store needs W. A fetch needs X. Otherwise the translation faults.
- R9: A valid leaf whose A bit is clear, or a store to a leaf whose D bit is clear, causes one compare-and-swap to the entry address. The compare value is the entry as read. The write value is the entry with A set, and also D set for a store. No write is issued when nothing changes.
- R10: If the compare-and-swap returns a word different from the compare value, the walk restarts with a read of the first-level entry. If memory flags an error on it, the translation faults.
- R11: The physical address is {ppn, vaddr[11:0]} for a second-level leaf. For a first-level leaf it is {ppn[21:10], vaddr[21:12], vaddr[11:0]}.
- R12: The grants are read = R or (X and MXR), execute = X, and write = W and (store or D already set). A fault returns address 0 and no grants.
- R13: `req_ready` is low from acceptance until the response is taken. The response stays valid and unchanged until `resp_ready`. A memory request stays valid and unchanged until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_access | input | 2 | 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| req_mprv | input | 1 | Data accesses use the previous privilege |
| req_mpp | input | 2 | Previous privilege |
| req_sum | input | 1 | Supervisor may touch user pages |
| req_mxr | input | 1 | Execute-only pages readable |
| req_root_ppn | input | 22 | Root table page number |
| req_paged | input | 1 | 1 two-level paging, 0 bare |
| resp_valid | output | 1 | Result present |
| resp_ready | input | 1 | Result taken |
| resp_paddr | output | 34 | Physical address |
| resp_r | output | 1 | Read granted |
| resp_w | output | 1 | Write granted |
| resp_x | output | 1 | Execute granted |
| resp_fault | output | 1 | Translation failed |
| busy | output | 1 | Translation in progress |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory request taken |
| mem_req_addr | output | 34 | Entry byte address |
| mem_req_write | output | 1 | 1 compare-and-swap, 0 read |
| mem_req_wdata | output | 32 | Swap value |
| mem_req_cmp | output | 32 | Compare value |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_data | input | 32 | Read word, or old word for a swap |
| mem_rsp_err | input | 1 | Swap could not be performed |

## Verification
The bench builds the walker with its default parameters: a 32-bit virtual address, 10-bit indices, 12-bit page offset, 22-bit page numbers and two levels. These values put both leaf levels within reach, so the bench can exercise superpage composition, superpage misalignment and a pointer at the last level with small tables. Memory is modelled as a sparse word store that can stall requests, corrupt an entry just before a swap, or refuse a swap. That lets the bench reach the restart and write-back error paths as well as the ordinary ones.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  localparam int B_V = 0;
  localparam int B_R = 1;
  localparam int B_W = 2;
  localparam int B_X = 3;
  localparam int B_U = 4;
  localparam int B_A = 6;
  localparam int B_D = 7;
  localparam int PPN_LSB = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_CAS_REQ, ST_CAS_WAIT, ST_RESP
  } walk_st_e;
endpackage

// File: rtl/ptw_mode_resolve.sv
module ptw_mode_resolve
  import ptw_pkg::*;
(
  input  logic [1:0] priv,
  input  logic [1:0] access,
  input  logic       mprv,
  input  logic [1:0] mpp,
  input  logic       paged,
  output logic [1:0] eff_priv,
  output logic       passthru
);
  always_comb begin
    eff_priv = priv;
    if (priv == PRV_M && access != ACC_FETCH && mprv) eff_priv = mpp;
    passthru = (eff_priv == PRV_M) || !paged;
  end
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int IDX_W    = 10,
  parameter int PG_SHIFT = 12,
  parameter int PPN_W    = 22,
  parameter int LEVELS   = 2,
  parameter int LVL_W    = 1,
  parameter int PTE_W    = PPN_W + PPN_LSB
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [LVL_W-1:0] lvl,
  input  logic [VA_W-1:0]  va,
  input  logic [1:0]       access,
  input  logic [1:0]       eff_priv,
  input  logic             sum,
  input  logic             mxr,
  output logic             is_ptr,
  output logic             is_fault,
  output logic [PTE_W-1:0] pte_upd,
  output logic [PPN_W-1:0] ppn_out,
  output logic             perm_r,
  output logic             perm_w,
  output logic             perm_x
);
  logic             v, r, w, x, u, d, leaf, last, rsvd, priv_bad, misal, acc_bad, is_st;
  logic [PPN_W-1:0] ppn, vpn, low_mask;
  int               shamt;

  always_comb begin
    v     = pte[B_V];
    r     = pte[B_R];
    w     = pte[B_W];
    x     = pte[B_X];
    u     = pte[B_U];
    d     = pte[B_D];
    is_st = (access == ACC_STORE);
    last  = (lvl == LVL_W'(LEVELS - 1));
    shamt = (LEVELS - 1 - int'(lvl)) * IDX_W;
    low_mask = (PPN_W'(1) << shamt) - PPN_W'(1);
    ppn   = pte[PTE_W-1:PPN_LSB];
    vpn   = PPN_W'(va[VA_W-1:PG_SHIFT]);
    leaf  = r | w | x;
    rsvd  = w & ~r;
    if (u) priv_bad = (eff_priv != PRV_U) && (!sum || access == ACC_FETCH);
    else   priv_bad = (eff_priv != PRV_S);
    misal = |(ppn & low_mask);
    case (access)
      ACC_LOAD:  acc_bad = !(r || (x && mxr));
      ACC_STORE: acc_bad = !w;
      ACC_FETCH: acc_bad = !x;
      default:   acc_bad = 1'b1;
    endcase
    is_ptr   = v && !leaf && !last;
    is_fault = !v || (!leaf && last) || (leaf && (rsvd || priv_bad || misal || acc_bad));
    pte_upd  = pte;
    pte_upd[B_A] = 1'b1;
    if (is_st) pte_upd[B_D] = 1'b1;
    ppn_out  = (ppn & ~low_mask) | (vpn & low_mask);
    perm_r   = r | (x & mxr);
    perm_x   = x;
    perm_w   = w & (is_st | d);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int IDX_W    = 10,
  parameter int PG_SHIFT = 12,
  parameter int PPN_W    = 22,
  parameter int LEVELS   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [VA_W-1:0]             req_vaddr,
  input  logic [1:0]                  req_access,
  input  logic [1:0]                  req_priv,
  input  logic                        req_mprv,
  input  logic [1:0]                  req_mpp,
  input  logic                        req_sum,
  input  logic                        req_mxr,
  input  logic [PPN_W-1:0]            req_root_ppn,
  input  logic                        req_paged,
  output logic                        resp_valid,
  input  logic                        resp_ready,
  output logic [PPN_W+PG_SHIFT-1:0]   resp_paddr,
  output logic                        resp_r,
  output logic                        resp_w,
  output logic                        resp_x,
  output logic                        resp_fault,
  output logic                        busy,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic [PPN_W+PG_SHIFT-1:0]   mem_req_addr,
  output logic                        mem_req_write,
  output logic [PPN_W+PPN_LSB-1:0]    mem_req_wdata,
  output logic [PPN_W+PPN_LSB-1:0]    mem_req_cmp,
  input  logic                        mem_rsp_valid,
  input  logic [PPN_W+PPN_LSB-1:0]    mem_rsp_data,
  input  logic                        mem_rsp_err
);
  localparam int PA_W   = PPN_W + PG_SHIFT;
  localparam int PTE_W  = PPN_W + PPN_LSB;
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int PTE_SH = $clog2(PTE_W / 8);

  walk_st_e         state_q, state_d;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q, eff_q;
  logic             sum_q, mxr_q;
  logic [PPN_W-1:0] root_q, base_q, base_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [PTE_W-1:0] pte_q, pte_d, upd_q, upd_d;
  logic [PA_W-1:0]  rpa_q, rpa_d;
  logic             rr_q, rr_d, rw_q, rw_d, rx_q, rx_d, rf_q, rf_d;
  logic             req_ld;

  logic [1:0]       in_eff;
  logic             in_pass;
  logic             ev_ptr, ev_fault, ev_r, ev_w, ev_x;
  logic [PTE_W-1:0] ev_upd;
  logic [PPN_W-1:0] ev_ppn;
  logic [IDX_W-1:0] idx;
  logic [PA_W-1:0]  ent_addr;
  int               idx_sh;

  ptw_mode_resolve u_mode (
    .priv(req_priv), .access(req_access), .mprv(req_mprv), .mpp(req_mpp),
    .paged(req_paged), .eff_priv(in_eff), .passthru(in_pass)
  );

  ptw_pte_eval #(
    .VA_W(VA_W), .IDX_W(IDX_W), .PG_SHIFT(PG_SHIFT), .PPN_W(PPN_W),
    .LEVELS(LEVELS), .LVL_W(LVL_W), .PTE_W(PTE_W)
  ) u_eval (
    .pte(mem_rsp_data), .lvl(lvl_q), .va(va_q), .access(acc_q), .eff_priv(eff_q),
    .sum(sum_q), .mxr(mxr_q), .is_ptr(ev_ptr), .is_fault(ev_fault),
    .pte_upd(ev_upd), .ppn_out(ev_ppn), .perm_r(ev_r), .perm_w(ev_w), .perm_x(ev_x)
  );

  // entry address from the current table base and level index
  always_comb begin
    idx_sh   = PG_SHIFT + (LEVELS - 1 - int'(lvl_q)) * IDX_W;
    idx      = IDX_W'(va_q >> idx_sh);
    ent_addr = {base_q, {PG_SHIFT{1'b0}}} + (PA_W'(idx) << PTE_SH);
  end

  assign req_ld = (state_q == ST_IDLE) && req_valid;

  // next-state logic
  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    lvl_d   = lvl_q;
    pte_d   = pte_q;
    upd_d   = upd_q;
    rpa_d   = rpa_q;
    rr_d    = rr_q;
    rw_d    = rw_q;
    rx_d    = rx_q;
    rf_d    = rf_q;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        if (in_pass) begin
          rpa_d = PA_W'(req_vaddr);
          rr_d = 1'b1; rw_d = 1'b1; rx_d = 1'b1; rf_d = 1'b0;
          state_d = ST_RESP;
        end else begin
          base_d  = req_root_ppn;
          lvl_d   = '0;
          state_d = ST_RD_REQ;
        end
      end
      ST_RD_REQ: if (mem_req_ready) state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (mem_rsp_valid) begin
        if (ev_fault) begin
          rpa_d = '0; rr_d = 1'b0; rw_d = 1'b0; rx_d = 1'b0; rf_d = 1'b1;
          state_d = ST_RESP;
        end else if (ev_ptr) begin
          base_d  = mem_rsp_data[PTE_W-1:PPN_LSB];
          lvl_d   = lvl_q + LVL_W'(1);
          state_d = ST_RD_REQ;
        end else begin
          pte_d = mem_rsp_data;
          upd_d = ev_upd;
          rpa_d = {ev_ppn, va_q[PG_SHIFT-1:0]};
          rr_d = ev_r; rw_d = ev_w; rx_d = ev_x; rf_d = 1'b0;
          state_d = (ev_upd != mem_rsp_data) ? ST_CAS_REQ : ST_RESP;
        end
      end
      ST_CAS_REQ: if (mem_req_ready) state_d = ST_CAS_WAIT;
      ST_CAS_WAIT: if (mem_rsp_valid) begin
        if (mem_rsp_err) begin
          rpa_d = '0; rr_d = 1'b0; rw_d = 1'b0; rx_d = 1'b0; rf_d = 1'b1;
          state_d = ST_RESP;
        end else if (mem_rsp_data != pte_q) begin
          base_d  = root_q;
          lvl_d   = '0;
          state_d = ST_RD_REQ;
        end else begin
          state_d = ST_RESP;
        end
      end
      ST_RESP: if (resp_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      lvl_q   <= '0;
      pte_q   <= '0;
      upd_q   <= '0;
      rpa_q   <= '0;
      rr_q    <= 1'b0;
      rw_q    <= 1'b0;
      rx_q    <= 1'b0;
      rf_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      lvl_q   <= lvl_d;
      pte_q   <= pte_d;
      upd_q   <= upd_d;
      rpa_q   <= rpa_d;
      rr_q    <= rr_d;
      rw_q    <= rw_d;
      rx_q    <= rx_d;
      rf_q    <= rf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      acc_q  <= '0;
      eff_q  <= '0;
      sum_q  <= 1'b0;
      mxr_q  <= 1'b0;
      root_q <= '0;
    end else if (req_ld) begin
      va_q   <= req_vaddr;
      acc_q  <= req_access;
      eff_q  <= in_eff;
      sum_q  <= req_sum;
      mxr_q  <= req_mxr;
      root_q <= req_root_ppn;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign busy          = (state_q != ST_IDLE);
  assign resp_valid    = (state_q == ST_RESP);
  assign resp_paddr    = rpa_q;
  assign resp_r        = rr_q;
  assign resp_w        = rw_q;
  assign resp_x        = rx_q;
  assign resp_fault    = rf_q;
  assign mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_CAS_REQ);
  assign mem_req_write = (state_q == ST_CAS_REQ);
  assign mem_req_addr  = ent_addr;
  assign mem_req_wdata = upd_q;
  assign mem_req_cmp   = pte_q;

  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));
  // R13
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_paddr) && $stable(resp_fault));
  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !resp_valid);
  // R12
  fault_noperm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> !(resp_r || resp_w || resp_x) && resp_paddr == '0);
  // R9
  cas_sets_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[B_A] && (mem_req_wdata != mem_req_cmp));
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  typedef logic [31:0] mem_t [int unsigned];
  typedef struct { logic [33:0] addr; bit wr; logic [31:0] wd; logic [31:0] cmp; } mreq_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0] req_access = '0, req_priv = '0, req_mpp = '0;
  logic req_mprv = 1'b0, req_sum = 1'b0, req_mxr = 1'b0, req_paged = 1'b0;
  logic [21:0] req_root_ppn = '0;
  logic resp_valid, resp_ready = 1'b1, resp_r, resp_w, resp_x, resp_fault, busy;
  logic [33:0] resp_paddr, mem_req_addr;
  logic mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_wdata, mem_req_cmp;
  logic mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_rsp_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0, stall_en = 0, inj_conflict = 0, inj_err = 0;
  int unsigned cyc = 0;
  mem_t tbmem;
  mreq_t exp_q[$];

  always #4 clk = ~clk;

  pt_walker u0 (.*);

  assign mem_req_ready = !stall_en || (cyc % 3 != 1);

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model with one-cycle response
  logic [31:0] old_w;
  int unsigned widx;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0; mem_rsp_err <= 1'b0; mem_rsp_data <= '0;
    end else begin
      cyc <= cyc + 1;
      mem_rsp_valid <= 1'b0; mem_rsp_err <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        widx = int'(mem_req_addr[33:2]);
        old_w = tbmem.exists(widx) ? tbmem[widx] : 32'h0;
        if (mem_req_write) begin
          if (inj_conflict) begin old_w = old_w | 32'h20; tbmem[widx] = old_w; inj_conflict = 0; end
          if (inj_err) begin mem_rsp_err <= 1'b1; inj_err = 0; end
          else if (old_w == mem_req_cmp) tbmem[widx] = mem_req_wdata;
        end
        mem_rsp_data <= old_w;
        mem_rsp_valid <= 1'b1;
      end
    end
  end

  // every memory request compared with the predicted sequence
  always @(negedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (exp_q.size() == 0) chk(0, "R3", "unexpected memory request", {30'd0, mem_req_addr}, 64'h0);
      else begin
        mreq_t e;
        e = exp_q.pop_front();
        if (e.wr) chk(mem_req_write && mem_req_addr == e.addr && mem_req_wdata == e.wd && mem_req_cmp == e.cmp,
                      "R9", "swap request", {mem_req_addr[31:0], mem_req_wdata}, {e.addr[31:0], e.wd});
        else chk(!mem_req_write && mem_req_addr == e.addr, "R3", "read address",
                 {30'd0, mem_req_addr}, {30'd0, e.addr});
      end
    end
  end

  // behavioural translation model
  function automatic void model(input mem_t m, input logic [31:0] va, input int acc, priv, mprv, mpp,
                                sum, mxr, input logic [21:0] root, input bit paged,
                                output bit f, output logic [33:0] pa, output bit r, w, x);
    int eff;
    longint base, a;
    int idx;
    logic [31:0] p, upd;
    logic [21:0] ppn;
    bit pr, pw, px, pu;
    eff = (priv == 3 && acc != 0 && mprv != 0) ? mpp : priv;
    f = 1; pa = '0; r = 0; w = 0; x = 0;
    if (eff == 3 || !paged) begin f = 0; pa = {2'b00, va}; r = 1; w = 1; x = 1; return; end
    base = longint'(root);
    for (int lvl = 0; lvl < 2; lvl++) begin
      idx = (lvl == 0) ? int'(va[31:22]) : int'(va[21:12]);
      a = base * 4096 + idx * 4;
      exp_q.push_back('{addr: 34'(a), wr: 0, wd: '0, cmp: '0});
      p = m.exists(int'(a >> 2)) ? m[int'(a >> 2)] : 32'h0;
      pr = p[1]; pw = p[2]; px = p[3]; pu = p[4];
      if (!p[0]) return;
      if (!pr && !pw && !px) begin base = longint'(p[31:10]); continue; end
      if (pw && !pr) return;
      if (pu && eff != 0 && (sum == 0 || acc == 0)) return;
      if (!pu && eff != 1) return;
      if (lvl == 0 && p[19:10] != 0) return;
      if (acc == 1 && !(pr || (px && mxr != 0))) return;
      if (acc == 2 && !pw) return;
      if (acc == 0 && !px) return;
      upd = p | 32'h40 | ((acc == 2) ? 32'h80 : 32'h0);
      if (upd != p) exp_q.push_back('{addr: 34'(a), wr: 1, wd: upd, cmp: p});
      ppn = (lvl == 0) ? {p[31:20], va[21:12]} : p[31:10];
      f = 0; pa = {ppn, va[11:0]};
      r = pr || (px && mxr != 0); x = px; w = pw && (acc == 2 || p[7]);
      return;
    end
  endfunction

  // kind: 0 normal, 1 entry changed before swap, 2 swap refused
  task automatic run(string req, logic [31:0] va, int acc, priv, mprv, mpp, sum, mxr, bit paged,
                     int kind, bit hold);
    bit f, r, w, x, df, dr, dw, dx;
    logic [33:0] pa, dpa;
    int t;
    mem_t cp;
    model(tbmem, va, acc, priv, mprv, mpp, sum, mxr, 22'h10, paged, f, pa, r, w, x);
    if (kind == 1) begin
      cp = tbmem;
      cp[(32'h20 * 4096 + va[21:12] * 4) >> 2] = cp[(32'h20 * 4096 + va[21:12] * 4) >> 2] | 32'h20;
      model(cp, va, acc, priv, mprv, mpp, sum, mxr, 22'h10, paged, f, pa, r, w, x);
      inj_conflict = 1;
    end
    if (kind == 2) begin f = 1; pa = '0; r = 0; w = 0; x = 0; inj_err = 1; end
    if (hold) resp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_access = 2'(acc); req_priv = 2'(priv);
    req_mprv = 1'(mprv); req_mpp = 2'(mpp); req_sum = 1'(sum); req_mxr = 1'(mxr);
    req_paged = paged; req_root_ppn = 22'h10;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!resp_valid && t < 300) begin @(negedge clk); t++; end
    if (!resp_valid) begin chk(0, req, "no response", 0, 1); return; end
    chk({resp_fault, resp_r, resp_w, resp_x, resp_paddr} == {f, r, w, x, pa}, req, "result",
        {26'd0, resp_fault, resp_r, resp_w, resp_x, resp_paddr}, {26'd0, f, r, w, x, pa});
    if (hold) begin
      {df, dr, dw, dx, dpa} = {resp_fault, resp_r, resp_w, resp_x, resp_paddr};
      repeat (2) @(negedge clk);
      chk(resp_valid && {resp_fault, resp_r, resp_w, resp_x, resp_paddr} == {df, dr, dw, dx, dpa},
          "R13", "held response", {63'd0, resp_valid}, 64'd1);
      chk(!req_ready && busy, "R13", "ready while busy", {62'd0, req_ready, busy}, 64'd1);
      resp_ready = 1'b1;
      @(negedge clk);
      chk(!resp_valid && req_ready, "R13", "release", {62'd0, resp_valid, req_ready}, 64'd1);
    end else @(negedge clk);
    chk(exp_q.size() == 0, req, "missing memory requests", exp_q.size(), 0);
    exp_q.delete();
  endtask

  function automatic void put(int tppn, int idx, logic [21:0] ppn, logic [7:0] fl);
    tbmem[(tppn * 4096 + idx * 4) >> 2] = {ppn, 2'b00, fl};
  endfunction

  initial begin
    // tables: root at ppn 0x10, second level at ppn 0x20
    put(16'h10, 1, 22'h20, 8'h01);
    put(16'h10, 2, 22'h400, 8'h4B);   // S superpage R X A
    put(16'h10, 3, 22'h401, 8'h4B);   // misaligned superpage
    put(16'h20, 3, 22'h345, 8'h17);   // U R W
    put(16'h20, 4, 22'h346, 8'hD3);   // U R A D
    put(16'h20, 5, 22'h347, 8'h59);   // U X A
    put(16'h20, 6, 22'h348, 8'h4F);   // S R W X A
    put(16'h20, 7, 22'h349, 8'h55);   // U W only
    put(16'h20, 8, 22'h34A, 8'h5D);   // U W X
    put(16'h20, 10, 22'h34B, 8'h01);  // pointer at last level
    put(16'h20, 11, 22'h34C, 8'hD7);  // U R W A D
    put(16'h20, 12, 22'h34D, 8'h13);  // U R, swap conflict
    put(16'h20, 13, 22'h34E, 8'h13);  // U R, swap refused
    repeat (3) @(negedge clk);
    chk(!busy && !resp_valid && !mem_req_valid, "R13", "reset outputs", {61'd0, busy, resp_valid, mem_req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R13", "ready after reset", {63'd0, req_ready}, 1);
    run("R2", 32'h1234_5678, 1, 3, 0, 0, 0, 0, 1, 0, 0);
    run("R2", 32'hFFFF_F000, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    run("R1", 32'h0040_3123, 1, 3, 1, 0, 0, 0, 1, 0, 0);
    run("R1", 32'h0040_3123, 0, 3, 1, 0, 0, 0, 1, 0, 0);
    stall_en = 1;
    run("R9", 32'h0040_3010, 2, 0, 0, 0, 0, 0, 1, 0, 0);
    run("R12", 32'h0040_3010, 2, 0, 0, 0, 0, 0, 1, 0, 0);
    run("R12", 32'h0040_B000, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    run("R12", 32'h0040_6444, 1, 1, 0, 0, 0, 0, 1, 0, 0);
    run("R11", 32'h0080_5ABC, 0, 1, 0, 0, 0, 0, 1, 0, 0);
    run("R7", 32'h00C0_0000, 1, 1, 0, 0, 0, 0, 1, 0, 0);
    run("R4", 32'h0040_9000, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    run("R4", 32'h0040_A000, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    run("R4", 32'h0100_0000, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    run("R5", 32'h0040_7000, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    run("R5", 32'h0040_8000, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    run("R6", 32'h0040_4000, 1, 1, 0, 0, 0, 0, 1, 0, 0);
    run("R6", 32'h0040_4000, 1, 1, 0, 0, 1, 0, 1, 0, 0);
    run("R6", 32'h0040_5000, 0, 1, 0, 0, 1, 0, 1, 0, 0);
    run("R6", 32'h0040_6000, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    run("R6", 32'h0040_6000, 2, 3, 1, 1, 0, 0, 1, 0, 0);
    run("R8", 32'h0040_5000, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    run("R8", 32'h0040_5000, 1, 0, 0, 0, 0, 1, 1, 0, 0);
    run("R8", 32'h0040_4000, 2, 0, 0, 0, 0, 0, 1, 0, 0);
    run("R8", 32'h0040_4000, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    run("R8", 32'h0040_5000, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    run("R10", 32'h0040_C000, 1, 0, 0, 0, 0, 0, 1, 1, 0);
    run("R10", 32'h0040_D000, 1, 0, 0, 0, 0, 0, 1, 2, 0);
    run("R13", 32'h0040_B000, 2, 0, 0, 0, 0, 0, 1, 0, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule